// File: doc/BRIEF.md
# GPIO Pin Event Interrupt Controller

This block watches one port of pin inputs and turns each pin's activity into events. Each pin is set to a trigger mode: rising edge, falling edge, either edge, or a steady logic level. An event sets that pin's sticky status flag. The mode code also decides where the flag is routed. It goes either to a shared DMA request line or to a shared interrupt line.

Software reaches the block through a simple register bus with address, write enable, write data and registered read data. Each pin has one control word that holds its mode and its flag. A separate status word gathers all pin flags in one place. Flags are cleared by writing 1s, either in the pin's control word or in the status word. A handler can therefore acknowledge an event by writing back the value it just read.

Pin inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After synchronous reset, every mode field and every flag is 0, and `irq_o` and `dma_req_o` are 0. A read of any register returns 0.
- R2: The control word of pin n is at byte offset 4*n. The mode code sits in bits 19:16 and the flag in bit 24. A write stores bits 19:16 as the new mode. All other bits of the control word read as 0. Read data appears one cycle after the address is presented.
- R3: Mode code 0 and the reserved codes (4 to 7 and 13 to 15) never set a flag, whatever the pin does.
- R4: Codes 1, 2 and 3 set the flag on a rising edge, a falling edge and either edge, respectively. These flags drive `dma_req_o` and never `irq_o`.
- R5: Codes 9, 10 and 11 set the flag on a rising edge, a falling edge and either edge, respectively. These flags drive `irq_o`.
- R6: Code 8 sets the flag while the pin is low, and code 12 sets it while the pin is high. If the pin is still at the active level, the flag sets again in the cycle after a clear.
- R7: Writing a control word with bit 24 at 1 clears that pin's flag. Writing it with bit 24 at 0 leaves the flag unchanged.
- R8: The status word at offset 0xA0 reads pin n's flag in bit n. Writing 1 to bit n clears pin n's flag, and writing 0 has no effect.
- R9: When a set and a clear reach a flag in the same cycle, the flag ends up set.
- R10: `irq_o` is the registered OR of the flags of pins in interrupt codes (8 to 12). `dma_req_o` is the registered OR of the flags of pins in DMA codes (1 to 3). Each output follows the flags by one cycle.
- R11: A pin edge driven between two clock edges sets the flag at the third rising clock edge after it. The matching output rises one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the port |
| bus_we | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 32 | Asynchronous pin inputs |
| irq_o | output | 1 | Interrupt request, OR of interrupt-mode flags |
| dma_req_o | output | 1 | DMA request, OR of DMA-mode flags |

## Verification
The bench checks the level modes against a clear arriving while the pin is still active. A design that let the clear win would show the flag dropping for one cycle, or staying down until the next edge. It checks that a falling-edge DMA pin ignores rising edges, and that a DMA-mode flag never reaches the interrupt line. A design that mixed up the routing would raise the wrong output. Control words written with bit 24 at 0 and status writes of 0 must leave flags alone, and reserved codes must stay silent; a design that cleared on any write, or decoded codes partially, would lose or invent flags. Random pin sequences over random per-pin modes exercise edges across all codes at once, compared with a bench model of the expected flag set.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int MODE_LSB = 16;
  localparam int MODE_W   = 4;
  localparam int FLAG_BIT = 24;
  localparam int STAT_OFS = 'hA0;

  typedef enum logic [MODE_W-1:0] {
    TRG_OFF      = 4'd0,
    TRG_DMA_RISE = 4'd1,
    TRG_DMA_FALL = 4'd2,
    TRG_DMA_ANY  = 4'd3,
    TRG_INT_LOW  = 4'd8,
    TRG_INT_RISE = 4'd9,
    TRG_INT_FALL = 4'd10,
    TRG_INT_ANY  = 4'd11,
    TRG_INT_HIGH = 4'd12
  } trig_e;

  function automatic logic trig_is_dma(input logic [MODE_W-1:0] m);
    return (m == TRG_DMA_RISE) || (m == TRG_DMA_FALL) || (m == TRG_DMA_ANY);
  endfunction

  function automatic logic trig_is_int(input logic [MODE_W-1:0] m);
    return (m >= TRG_INT_LOW) && (m <= TRG_INT_HIGH);
  endfunction

  // event condition for one pin given current and previous synchronized value
  function automatic logic trig_hit(input logic [MODE_W-1:0] m,
                                    input logic cur, input logic prv);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    case (m)
      TRG_DMA_RISE, TRG_INT_RISE: return rise;
      TRG_DMA_FALL, TRG_INT_FALL: return fall;
      TRG_DMA_ANY,  TRG_INT_ANY:  return rise | fall;
      TRG_INT_LOW:                return ~cur;
      TRG_INT_HIGH:               return cur;
      default:                    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign cur = sync_q;
  assign prv = last_q;
endmodule

// File: rtl/gpio_evt_cell.sv
module gpio_evt_cell
  import gpio_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cur,
  input  logic              prv,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wr,
  input  logic              clr,
  output logic [MODE_W-1:0] mode_q,
  output logic              flag_q
);
  logic hit;

  assign hit = trig_hit(mode_q, cur, prv);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wr;
      flag_q <= hit | (flag_q & ~clr);
    end
  end
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic          irq_o,
  output logic          dma_req_o
);
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [AW-1:0] CTRL_END = AW'(4 * NPINS);
  localparam logic [AW-1:0] STAT_A   = AW'(STAT_OFS);

  logic [NPINS-1:0]             pin_cur, pin_prv;
  logic [NPINS-1:0]             flag_q;
  logic [NPINS-1:0][MODE_W-1:0] mode_q;
  logic [NPINS-1:0]             int_vec, dma_vec;
  logic                         in_ctrl, sta_hit;
  logic [IW-1:0]                idx;
  logic [DW-1:0]                rdata_d;

  gpio_evt_sync #(.W(NPINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw (pin_in),
    .cur (pin_cur),
    .prv (pin_prv)
  );

  assign in_ctrl = (bus_addr < CTRL_END) && (bus_addr[1:0] == 2'b00);
  assign sta_hit = (bus_addr == STAT_A);
  assign idx     = bus_addr[IW+1:2];

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic sel, clr;
    assign sel = bus_we && in_ctrl && (idx == IW'(i));
    assign clr = (sel && bus_wdata[FLAG_BIT]) || (bus_we && sta_hit && bus_wdata[i]);

    gpio_evt_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .cur     (pin_cur[i]),
      .prv     (pin_prv[i]),
      .mode_we (sel),
      .mode_wr (bus_wdata[MODE_LSB +: MODE_W]),
      .clr     (clr),
      .mode_q  (mode_q[i]),
      .flag_q  (flag_q[i])
    );

    assign int_vec[i] = flag_q[i] & trig_is_int(mode_q[i]);
    assign dma_vec[i] = flag_q[i] & trig_is_dma(mode_q[i]);
  end

  always_comb begin
    rdata_d = '0;
    if (in_ctrl) begin
      rdata_d[MODE_LSB +: MODE_W] = mode_q[idx];
      rdata_d[FLAG_BIT]           = flag_q[idx];
    end else if (sta_hit) begin
      rdata_d[NPINS-1:0] = flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      irq_o     <= |int_vec;
      dma_req_o <= |dma_vec;
    end
  end
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic [AW-1:0]                bus_addr,
  input logic [DW-1:0]                bus_rdata,
  input logic [NPINS-1:0]             flag,
  input logic [NPINS-1:0][MODE_W-1:0] mode,
  input logic [NPINS-1:0]             sync,
  input logic                         irq_o,
  input logic                         dma_req_o
);
  localparam logic [AW-1:0] CTRL_END = AW'(4 * NPINS);
  localparam logic [AW-1:0] STAT_A   = AW'(STAT_OFS);
  localparam logic [DW-1:0] KEEP     = (DW'(4'hF) << MODE_LSB) | (DW'(1) << FLAG_BIT);

  logic int_any, dma_any, rd_ctrl, rd_stat;

  always_comb begin
    int_any = 1'b0;
    dma_any = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (flag[i] && trig_is_int(mode[i])) int_any = 1'b1;
      if (flag[i] && trig_is_dma(mode[i])) dma_any = 1'b1;
    end
  end

  assign rd_ctrl = bus_addr < CTRL_END;
  assign rd_stat = bus_addr == STAT_A;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !dma_req_o && bus_rdata == '0));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    int_any |=> irq_o);
  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !int_any |=> !irq_o);
  // R10
  dma_follow_chk: assert property (@(posedge clk) disable iff (rst)
    dma_any |=> dma_req_o);
  // R10
  dma_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_any |=> !dma_req_o);

  // R2
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl |=> ((bus_rdata & ~KEEP) == '0));

  // R8
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (bus_rdata[NPINS-1:0] == $past(flag)));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
    // R3
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!flag[i] && !trig_is_int(mode[i]) && !trig_is_dma(mode[i])) |=> !flag[i]);
    // R6 R9
    level_set_chk: assert property (@(posedge clk) disable iff (rst)
      ((mode[i] == TRG_INT_HIGH && sync[i]) || (mode[i] == TRG_INT_LOW && !sync[i]))
        |=> flag[i]);
  end
endmodule

bind gpio_evt_ctrl gpio_evt_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .flag      (flag_q),
  .mode      (mode_q),
  .sync      (pin_cur),
  .irq_o     (irq_o),
  .dma_req_o (dma_req_o)
);

// File: tb/tb_gpio_evt_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic        irq_o, dma_req_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic [3:0] bmode [32];

  always #2.5 clk = ~clk;

  gpio_evt_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    bus_we   = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(input logic [3:0] m, input logic f);
    return {7'b0, f, 4'b0, m, 16'b0};
  endfunction

  // flags set by one transition from o to n, under the requirement codes
  function automatic logic [31:0] edge_ev(input logic [31:0] o, input logic [31:0] n);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      case (bmode[i])
        4'd1, 4'd9:  r[i] = !o[i] && n[i];
        4'd2, 4'd10: r[i] = o[i] && !n[i];
        4'd3, 4'd11: r[i] = o[i] != n[i];
        default:     r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] lvl_ev(input logic [31:0] n);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      r[i] = (bmode[i] == 4'd8 && !n[i]) || (bmode[i] == 4'd12 && n[i]);
    end
    return r;
  endfunction

  function automatic logic [31:0] int_mask();
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = bmode[i] >= 4'd8 && bmode[i] <= 4'd12;
    return r;
  endfunction

  function automatic logic [31:0] dma_mask();
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[i] = bmode[i] >= 4'd1 && bmode[i] <= 4'd3;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, vec, nv, exp;
    logic [3:0]  codes [11];
    codes = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd5, 4'd14};
    void'($urandom(32'd20240611));

    tick(4);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq_o", {31'b0, irq_o}, 32'h0);
    check("R1 dma_req_o", {31'b0, dma_req_o}, 32'h0);
    brd(12'hA0, v);  check("R1 status", v, 32'h0);
    brd(12'h014, v); check("R1 ctrl pin5", v, 32'h0);

    // R2 layout: only mode and flag bits survive
    bwr(12'h00C, 32'hFFFF_FFFF);
    brd(12'h00C, v); check("R2 ctrl all-ones write", v, 32'h000F_0000);
    bwr(12'h00C, ctl(4'd9, 1'b0));
    brd(12'h00C, v); check("R2 ctrl mode 9", v, 32'h0009_0000);

    // R11 / R5 rising-edge interrupt timing on pin 3
    pin_in[3] = 1'b1;
    tick(3);
    check("R11 irq low before output register", {31'b0, irq_o}, 32'h0);
    tick(1);
    check("R11 irq after four edges", {31'b0, irq_o}, 32'h1);
    check("R5 dma stays low", {31'b0, dma_req_o}, 32'h0);
    brd(12'h00C, v); check("R5 ctrl pin3 flag", v, 32'h0109_0000);

    // R7 write-1-to-clear in control word
    bwr(12'h00C, ctl(4'd9, 1'b0));
    brd(12'h00C, v); check("R7 bit24=0 keeps flag", v, 32'h0109_0000);
    bwr(12'h00C, ctl(4'd9, 1'b1));
    brd(12'h00C, v); check("R7 bit24=1 clears flag", v, 32'h0009_0000);
    check("R7 irq drops", {31'b0, irq_o}, 32'h0);

    // R6 / R9 level high on pin 7, clear collides with set
    bwr(12'h01C, ctl(4'd12, 1'b0));
    pin_in[7] = 1'b1;
    tick(4);
    brd(12'hA0, v); check("R6 level flag", v, 32'h0000_0080);
    bwr(12'hA0, 32'h0000_0080);
    brd(12'hA0, v); check("R9 set wins over clear", v, 32'h0000_0080);
    check("R6 irq from level", {31'b0, irq_o}, 32'h1);
    pin_in[7] = 1'b0;
    tick(4);
    bwr(12'hA0, 32'h0000_0080);
    brd(12'hA0, v); check("R8 status clear", v, 32'h0);
    tick(1);
    check("R10 irq idle", {31'b0, irq_o}, 32'h0);

    // R3 reserved and off codes stay silent
    bwr(12'h030, ctl(4'd5, 1'b0));
    bwr(12'h034, ctl(4'd0, 1'b0));
    pin_in[13:12] = 2'b11; tick(5);
    pin_in[13:12] = 2'b00; tick(5);
    brd(12'hA0, v); check("R3 no flags", v, 32'h0);

    // R4 falling-edge DMA on pin 10
    bwr(12'h028, ctl(4'd2, 1'b0));
    pin_in[10] = 1'b1; tick(5);
    check("R4 rising ignored", {31'b0, dma_req_o}, 32'h0);
    pin_in[10] = 1'b0; tick(4);
    check("R4 dma on fall", {31'b0, dma_req_o}, 32'h1);
    check("R4 irq untouched", {31'b0, irq_o}, 32'h0);
    brd(12'h028, v); check("R4 ctrl pin10", v, 32'h0102_0000);

    // random phase
    pin_in = '0;
    tick(6);
    vec = '0;
    for (int i = 0; i < 32; i++) begin
      bmode[i] = codes[$urandom % 11];
      bwr(12'(4 * i), ctl(bmode[i], 1'b1));
    end
    bwr(12'hA0, 32'hFFFF_FFFF);
    tick(3);
    exp = lvl_ev(vec);
    for (int it = 0; it < 24; it++) begin
      nv = $urandom;
      exp = exp | edge_ev(vec, nv) | lvl_ev(nv);
      pin_in = nv;
      tick(6);
      brd(12'hA0, v); check("R4 R5 R6 R3 random flags", v, exp);
      check("R10 random irq", {31'b0, irq_o}, {31'b0, |(exp & int_mask())});
      check("R10 random dma", {31'b0, dma_req_o}, {31'b0, |(exp & dma_mask())});
      bwr(12'hA0, 32'h0);
      brd(12'hA0, v); check("R8 zero write no effect", v, exp);
      if (it % 2 == 1) begin
        bwr(12'hA0, 32'hFFFF_FFFF);
        tick(2);
        exp = lvl_ev(nv);
        brd(12'hA0, v); check("R8 R6 clear-all leaves active levels", v, exp);
      end
      vec = nv;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule